// File: doc/BRIEF.md
# Last-Level Cache Slice Coherence Directory

This block is the coherence controller for one slice of a shared, inclusive last-level cache. Each line of the slice has a tag entry with a coherence state and the identity of the single core, if any, that holds a private copy with ownership. Cores send share-requests, read-for-ownership (RFO) requests and write-backs over a valid/ready request port. The slice either answers straight from its own data copy or sends a recall message to the one core that owns the line. Because the directory names that core, no snoop is broadcast. When the owner replies, the slice finishes the original request.

The slice holds the backing copy of every line, and that copy is zero after reset. It runs one transaction at a time. A request is accepted, the tag entry is examined in the next cycle, and the request port stays closed until the response has been taken. Recalls and responses are held until their receiver is ready. The owner's reply carries a flag that says whether it returns data. A clean Exclusive copy may have been dropped silently, and its owner answers without data. An Exclusive owner may also have upgraded its copy to Modified without telling the slice, so the slice treats every owned line as possibly dirty and always recalls it.

Top module: `llc_coherence_slice`

## Requirements
- R1: After reset every line has no private copy and holds data zero, `req_ready` is 1, and `rsp_valid` and `rcl_valid` are 0.
- R2: A share-request (`req_type` 2'b00, or the reserved 2'b11) to a line with no private copy is answered with grant Exclusive (`rsp_grant` 2'b10) and the slice's data, and the requester is recorded as the owner.
- R3: A share-request to a Shared line is answered with grant Shared (2'b01) and the slice's data, and no recall is sent.
- R4: A share-request to a line owned by another core sends a recall to that owner with `rcl_inval`=0. After the owner's reply, the requester gets grant Shared, and the line becomes Shared with no owner recorded.
- R5: An RFO (`req_type` 2'b01) to a line owned by another core sends a recall to that owner with `rcl_inval`=1. After the reply, the requester gets grant Exclusive and is recorded as the new owner.
- R6: An owner reply with `ack_has_data`=1 replaces the slice's copy of the line and is forwarded to the requester. A reply with `ack_has_data`=0 leaves the copy unchanged, and the slice supplies that copy.
- R7: A write-back (`req_type` 2'b10) from the recorded owner stores `req_data` and leaves the line with no private copy. A write-back from any other core changes nothing. Both are answered with grant None (2'b00).
- R8: A share-request or RFO from the core that already owns the line is answered directly with grant Exclusive and no recall.
- R9: The tag check takes place one cycle after a request is accepted. The response or recall appears on the second rising edge after acceptance, `rsp_core` names the requester, and `req_ready` stays 0 until the response has been taken.
- R10: An owner reply is taken only while a recall is outstanding and only from the recalled core. All other replies are ignored.
- R11: `rsp_valid` and `rcl_valid`, and their fields, stay unchanged while the matching ready input is 0.
- R12: An RFO to a Shared line or to a line with no private copy is answered directly with grant Exclusive, and the requester is recorded as the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Slice can accept a request |
| req_core | input | $clog2(NCORES) | Requesting core |
| req_type | input | 2 | 00 share, 01 RFO, 10 write-back, 11 treated as share |
| req_line | input | $clog2(NLINES) | Line index |
| req_data | input | DW | Write-back data |
| rsp_valid | output | 1 | Response message present |
| rsp_ready | input | 1 | Response taken |
| rsp_core | output | $clog2(NCORES) | Core the response is for |
| rsp_grant | output | 2 | 00 none, 01 Shared, 10 Exclusive |
| rsp_data | output | DW | Line data |
| rcl_valid | output | 1 | Recall message present |
| rcl_ready | input | 1 | Recall taken |
| rcl_core | output | $clog2(NCORES) | Owner being recalled |
| rcl_line | output | $clog2(NLINES) | Line being recalled |
| rcl_inval | output | 1 | 1 invalidate, 0 downgrade to Shared |
| ack_valid | input | 1 | Owner reply present |
| ack_core | input | $clog2(NCORES) | Replying core |
| ack_has_data | input | 1 | Reply carries data |
| ack_data | input | DW | Returned line data |

## Verification
The two functions that can meet in one cycle are the completion of a recall and the arrival of a new request. The bench drives the owner's reply and another core's share-request to the same line on the same clock edge. It then expects the reply to complete the first transaction while the new request waits with `req_ready` low. After that, the waiting request must be served straight from the newly Shared line, and its data must be the data the owner returned.

// File: rtl/llc_coherence_slice.sv
module llc_coherence_slice #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [$clog2(NCORES)-1:0] req_core,
  input  logic [1:0]                req_type,
  input  logic [$clog2(NLINES)-1:0] req_line,
  input  logic [DW-1:0]             req_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [$clog2(NCORES)-1:0] rsp_core,
  output logic [1:0]                rsp_grant,
  output logic [DW-1:0]             rsp_data,
  output logic                      rcl_valid,
  input  logic                      rcl_ready,
  output logic [$clog2(NCORES)-1:0] rcl_core,
  output logic [$clog2(NLINES)-1:0] rcl_line,
  output logic                      rcl_inval,
  input  logic                      ack_valid,
  input  logic [$clog2(NCORES)-1:0] ack_core,
  input  logic                      ack_has_data,
  input  logic [DW-1:0]             ack_data
);
  localparam int CW = $clog2(NCORES);
  localparam int IW = $clog2(NLINES);
  localparam int OW = $clog2(NCORES + 1);
  localparam logic [OW-1:0] NO_OWNER = OW'(NCORES);

  localparam logic [1:0] LN_NONE = 2'd0;
  localparam logic [1:0] LN_SHR  = 2'd1;
  localparam logic [1:0] LN_OWN  = 2'd2;

  localparam logic [1:0] GR_NONE = 2'd0;
  localparam logic [1:0] GR_SHR  = 2'd1;
  localparam logic [1:0] GR_EXC  = 2'd2;

  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_RCL, F_WAIT, F_RSP} fsm_t;
  fsm_t fsm;

  logic [1:0]    st_q  [NLINES];
  logic [OW-1:0] own_q [NLINES];
  logic [DW-1:0] dat_q [NLINES];

  logic [CW-1:0] q_core;
  logic [1:0]    q_type;
  logic [IW-1:0] q_line;
  logic [DW-1:0] q_data;

  wire           q_rfo     = (q_type == 2'd1);
  wire           q_wb      = (q_type == 2'd2);
  wire [1:0]     cur_st    = st_q[q_line];
  wire [OW-1:0]  cur_own   = own_q[q_line];
  wire [DW-1:0]  cur_dat   = dat_q[q_line];
  wire           self_own  = (cur_st == LN_OWN) && (cur_own == OW'(q_core));
  wire           other_own = (cur_st == LN_OWN) && !self_own;
  wire           ack_take  = (fsm == F_WAIT) && ack_valid && (ack_core == rcl_core);

  assign req_ready = (fsm == F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_grant <= GR_NONE;
      rsp_data  <= '0;
      rcl_valid <= 1'b0;
      rcl_core  <= '0;
      rcl_line  <= '0;
      rcl_inval <= 1'b0;
      q_core    <= '0;
      q_type    <= '0;
      q_line    <= '0;
      q_data    <= '0;
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= LN_NONE;
        own_q[i] <= NO_OWNER;
        dat_q[i] <= '0;
      end
    end else begin
      case (fsm)
        F_IDLE: if (req_valid) begin
          q_core <= req_core;
          q_type <= req_type;
          q_line <= req_line;
          q_data <= req_data;
          fsm    <= F_LOOK;
        end
        F_LOOK: begin
          rsp_core <= q_core;
          if (q_wb) begin
            if (self_own) begin
              dat_q[q_line] <= q_data;
              st_q[q_line]  <= LN_NONE;
              own_q[q_line] <= NO_OWNER;
            end
            rsp_grant <= GR_NONE;
            rsp_data  <= '0;
            rsp_valid <= 1'b1;
            fsm       <= F_RSP;
          end else if (other_own) begin
            rcl_core  <= cur_own[CW-1:0];
            rcl_line  <= q_line;
            rcl_inval <= q_rfo;
            rcl_valid <= 1'b1;
            fsm       <= F_RCL;
          end else begin
            rsp_data  <= cur_dat;
            rsp_valid <= 1'b1;
            fsm       <= F_RSP;
            if (cur_st == LN_SHR && !q_rfo) begin
              rsp_grant <= GR_SHR;
            end else begin
              rsp_grant     <= GR_EXC;
              st_q[q_line]  <= LN_OWN;
              own_q[q_line] <= OW'(q_core);
            end
          end
        end
        F_RCL: if (rcl_ready) begin
          rcl_valid <= 1'b0;
          fsm       <= F_WAIT;
        end
        F_WAIT: if (ack_take) begin
          if (ack_has_data) dat_q[q_line] <= ack_data;
          rsp_data  <= ack_has_data ? ack_data : cur_dat;
          rsp_valid <= 1'b1;
          fsm       <= F_RSP;
          if (q_rfo) begin
            rsp_grant     <= GR_EXC;
            st_q[q_line]  <= LN_OWN;
            own_q[q_line] <= OW'(q_core);
          end else begin
            rsp_grant     <= GR_SHR;
            st_q[q_line]  <= LN_SHR;
            own_q[q_line] <= NO_OWNER;
          end
        end
        F_RSP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          fsm       <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llc_slice_chk.sv
module llc_slice_chk #(
  parameter int NCORES = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [$clog2(NCORES)-1:0] req_core,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [$clog2(NCORES)-1:0] rsp_core,
  input logic [1:0]                rsp_grant,
  input logic                      rcl_valid,
  input logic                      rcl_ready,
  input logic [$clog2(NCORES)-1:0] rcl_core
);
  assert_one_message_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rcl_valid));

  assert_busy_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || rcl_valid) |-> !req_ready);

  assert_lookup_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_valid && !rcl_valid));

  assert_lookup_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 (rsp_valid || rcl_valid));

  assert_rsp_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##2 rsp_valid |-> rsp_core == $past(req_core, 2));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_core) && $stable(rsp_grant));

  assert_rcl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_valid && !rcl_ready) |=> rcl_valid && $stable(rcl_core));
endmodule

bind llc_coherence_slice llc_slice_chk #(.NCORES(NCORES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_core(req_core), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_core(rsp_core), .rsp_grant(rsp_grant), .rcl_valid(rcl_valid),
  .rcl_ready(rcl_ready), .rcl_core(rcl_core)
);

// File: tb/llc_coherence_slice_tb.sv
`timescale 1ns/1ps
module llc_coherence_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_core = '0;
  logic [1:0]  req_type = '0;
  logic [3:0]  req_line = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_core;
  logic [1:0]  rsp_grant;
  logic [31:0] rsp_data;
  logic        rcl_valid;
  logic        rcl_ready = 1'b1;
  logic [1:0]  rcl_core;
  logic [3:0]  rcl_line;
  logic        rcl_inval;
  logic        ack_valid = 1'b0;
  logic [1:0]  ack_core = '0;
  logic        ack_has_data = 1'b0;
  logic [31:0] ack_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  llc_coherence_slice dut_i (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input int c, input int t, input int l, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(c); req_type = 2'(t); req_line = 4'(l); req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(input int c, input logic [1:0] g, input logic [31:0] d,
                         input string tag, output bit saw_rcl);
    int n = 0;
    saw_rcl = 1'b0;
    while (!rsp_valid && n < 50) begin
      if (rcl_valid) saw_rcl = 1'b1;
      @(negedge clk); n++;
    end
    check(rsp_valid, tag, "rsp_valid", 32'(rsp_valid), 1);
    check(rsp_core == 2'(c), tag, "rsp_core", 32'(rsp_core), 32'(c));
    check(rsp_grant == g, tag, "rsp_grant", 32'(rsp_grant), 32'(g));
    check(rsp_data == d, tag, "rsp_data", rsp_data, d);
    @(negedge clk);
  endtask

  task automatic get_rcl(input int c, input bit inv, input int l, input string tag);
    int n = 0;
    while (!rcl_valid && n < 50) begin @(negedge clk); n++; end
    check(rcl_valid, tag, "rcl_valid", 32'(rcl_valid), 1);
    check(rcl_core == 2'(c), tag, "rcl_core", 32'(rcl_core), 32'(c));
    check(rcl_inval == inv, tag, "rcl_inval", 32'(rcl_inval), 32'(inv));
    check(rcl_line == 4'(l), tag, "rcl_line", 32'(rcl_line), 32'(l));
    @(negedge clk);
  endtask

  task automatic ack(input int c, input bit hd, input logic [31:0] d);
    @(negedge clk);
    ack_valid = 1'b1; ack_core = 2'(c); ack_has_data = hd; ack_data = d;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    check(!rsp_valid && !rcl_valid, "R1", "outputs idle", 32'({rsp_valid, rcl_valid}), 0);
  endtask

  task automatic t_first_read;
    bit s;
    send(0, 0, 3, 0);
    check(!rsp_valid && !rcl_valid, "R9", "nothing during tag check", 32'(rsp_valid), 0);
    @(negedge clk);
    check(rsp_valid, "R9", "response on second edge", 32'(rsp_valid), 1);
    get_rsp(0, 2'b10, 32'h0, "R2", s);
    send(1, 3, 9, 0);
    get_rsp(1, 2'b10, 32'h0, "R1", s);
  endtask

  task automatic t_owner_self;
    bit s;
    send(0, 1, 3, 0);
    get_rsp(0, 2'b10, 32'h0, "R8", s);
    check(!s, "R8", "no recall", 32'(s), 0);
  endtask

  task automatic t_share_recall;
    bit s;
    send(1, 0, 3, 0);
    get_rcl(0, 1'b0, 3, "R4");
    ack(0, 1'b1, 32'hAAAA_0001);
    get_rsp(1, 2'b01, 32'hAAAA_0001, "R4", s);
    send(2, 0, 3, 0);
    get_rsp(2, 2'b01, 32'hAAAA_0001, "R3", s);
    check(!s, "R3", "no recall on Shared hit", 32'(s), 0);
  endtask

  task automatic t_rfo_chain;
    bit s;
    send(2, 1, 3, 0);
    get_rsp(2, 2'b10, 32'hAAAA_0001, "R12", s);
    check(!s, "R12", "no recall", 32'(s), 0);
    send(3, 1, 3, 0);
    get_rcl(2, 1'b1, 3, "R5");
    ack(2, 1'b0, 32'hDEAD_DEAD);
    get_rsp(3, 2'b10, 32'hAAAA_0001, "R6", s);
  endtask

  task automatic t_writeback;
    bit s;
    send(3, 2, 3, 32'hBBBB_0002);
    get_rsp(3, 2'b00, 32'h0, "R7", s);
    send(1, 0, 3, 0);
    get_rsp(1, 2'b10, 32'hBBBB_0002, "R7", s);
    check(!s, "R7", "line left uncached", 32'(s), 0);
    send(2, 2, 3, 32'hCCCC_0003);
    get_rsp(2, 2'b00, 32'h0, "R7", s);
    send(1, 0, 3, 0);
    get_rsp(1, 2'b10, 32'hBBBB_0002, "R7", s);
    check(!s, "R7", "non-owner write-back ignored", 32'(s), 0);
  endtask

  task automatic t_stray_acks;
    bit s;
    rcl_ready = 1'b0;
    send(0, 1, 3, 0);
    @(negedge clk);
    @(negedge clk);
    check(rcl_valid && rcl_core == 2'd1, "R11", "recall held", 32'(rcl_valid), 1);
    rcl_ready = 1'b1;
    get_rcl(1, 1'b1, 3, "R5");
    ack(2, 1'b1, 32'hDDDD_0004);
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R10", "wrong-core reply ignored", 32'(rsp_valid), 0);
    ack(1, 1'b1, 32'hEEEE_0005);
    get_rsp(0, 2'b10, 32'hEEEE_0005, "R5", s);
    ack(0, 1'b1, 32'h1234_5678);
    send(0, 0, 3, 0);
    get_rsp(0, 2'b10, 32'hEEEE_0005, "R10", s);
  endtask

  task automatic t_hold;
    bit s;
    rsp_ready = 1'b0;
    send(1, 0, 5, 0);
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid && rsp_grant == 2'b10, "R11", "response held", 32'(rsp_valid), 1);
      check(!req_ready, "R9", "requests stalled", 32'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    get_rsp(1, 2'b10, 32'h0, "R11", s);
  endtask

  task automatic t_collide;
    bit s;
    send(1, 0, 7, 0);
    get_rsp(1, 2'b10, 32'h0, "R2", s);
    send(2, 0, 7, 0);
    get_rcl(1, 1'b0, 7, "R4");
    ack_valid = 1'b1; ack_core = 2'd1; ack_has_data = 1'b1; ack_data = 32'h7777_0007;
    req_valid = 1'b1; req_core = 2'd3; req_type = 2'd0; req_line = 4'd7;
    @(negedge clk);
    ack_valid = 1'b0;
    check(!req_ready, "R9", "new request waits", 32'(req_ready), 0);
    get_rsp(2, 2'b01, 32'h7777_0007, "R4", s);
    @(negedge clk);
    req_valid = 1'b0;
    get_rsp(3, 2'b01, 32'h7777_0007, "R3", s);
    check(!s, "R3", "waiting request served directly", 32'(s), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_read();
    t_owner_self();
    t_share_recall();
    t_rfo_chain();
    t_writeback();
    t_stray_acks();
    t_hold();
    t_collide();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule